// File: doc/BRIEF.md
# Operator Phase Increment Generator

This block turns the pitch settings of an FM synthesis operator into the amount its phase accumulator advances each sample. It takes an 11-bit frequency number, a 3-bit octave value, a phase-modulation sensitivity and a signed phase-modulation offset. The offset comes from an external lookup. When the sensitivity is non-zero, the block doubles the frequency number, adds the offset and wraps the sum to 12 bits. It then scales the result by the octave. Detune, the frequency multiple and the contents of the modulation table are handled elsewhere.

One channel can run in a per-operator pitch mode. In that mode, operators 0 to 2 each take their pitch from their own supplementary register set instead of the channel registers. Operator 3 keeps the channel settings.

Requests arrive on a valid/ready stream and results leave on another. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid`/`out_inc` from the next cycle on. It stays there, unchanged, until it is taken on an edge with `out_ready` high. `in_ready` is high when the output register is empty or is being drained in the same cycle. A stalled output therefore back-pressures the input with no loss.

Top module: `pinc_gen`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `out_inc` is 0 and `in_ready` is 1.
- R2: With `pms` equal to 0, the 11-bit frequency number is used unchanged as the base value, and `pm_ofs` has no effect.
- R3: With `pms` non-zero, the base is twice the frequency number plus the sign-extended 8-bit two's-complement `pm_ofs`, taken modulo 4096.
- R4: With octave 0, the increment is the base shifted right by one bit, so it is always below 2048.
- R5: With octave n from 1 to 7, the increment is the base shifted left by n−1 bits. The output is 18 bits wide, so no case can overflow.
- R6: With `spec_en` high and `op_idx` 0, 1 or 2, the frequency number and octave come from supplementary set `op_idx`. Set k sits at `sup_fnum[11k+10:11k]` and `sup_block[3k+2:3k]`. With `op_idx` 3, or with `spec_en` low, the channel registers are used and `op_idx` is ignored.
- R7: An accepted request raises `out_valid` on the next cycle. A result consumed with no new request leaves `out_valid` low on the following cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_inc` holds its value and `in_ready` is low. No new request is accepted during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| spec_en | input | 1 | Per-operator pitch mode for this request |
| op_idx | input | 2 | Operator number within the channel |
| chan_fnum | input | 11 | Channel frequency number |
| chan_block | input | 3 | Channel octave |
| sup_fnum | input | 33 | Three packed supplementary frequency numbers |
| sup_block | input | 9 | Three packed supplementary octaves |
| pms | input | 3 | Phase-modulation sensitivity, 0 = off |
| pm_ofs | input | 8 | Signed phase-modulation offset from lookup |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_inc | output | 18 | Phase increment before detune and multiple |

## Verification
The assertions check the stream rules on every cycle. These are the one-cycle latency, the return to idle once a result is consumed, and a stalled result holding steady. They also check that an octave-0 result never exceeds eleven bits. The arithmetic can only be shown by the bench's scenarios. This covers the 12-bit wrap for both positive and negative offsets, the choice between supplementary and channel sets, the ignored operator number outside the special mode, and the largest octave-7 result. A stall that lasts several cycles before release is also covered only by the bench.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  parameter int FNUM_W  = 11;
  parameter int BLK_W   = 3;
  parameter int PM_W    = 8;
  parameter int PMS_W   = 3;
  parameter int NUM_SUP = 3;

  localparam int SUM_W     = FNUM_W + 1;
  localparam int MAX_SHIFT = (1 << BLK_W) - 2;
  localparam int INC_W     = SUM_W + MAX_SHIFT;
  localparam int OP_W      = $clog2(NUM_SUP + 1);

  typedef struct packed {
    logic [FNUM_W-1:0] fnum;
    logic [BLK_W-1:0]  blk;
  } pitch_t;
endpackage

// File: rtl/pinc_src_sel.sv
module pinc_src_sel
  import pinc_pkg::*;
(
  input  logic                      spec_en,
  input  logic [OP_W-1:0]           op_idx,
  input  pitch_t                    chan_pitch,
  input  logic [NUM_SUP*FNUM_W-1:0] sup_fnum,
  input  logic [NUM_SUP*BLK_W-1:0]  sup_block,
  output pitch_t                    sel_pitch
);
  pitch_t sup_set [NUM_SUP];

  for (genvar k = 0; k < NUM_SUP; k++) begin : g_unpack
    assign sup_set[k].fnum = sup_fnum[k*FNUM_W +: FNUM_W];
    assign sup_set[k].blk  = sup_block[k*BLK_W +: BLK_W];
  end

  always_comb begin
    sel_pitch = chan_pitch;
    if (spec_en) begin
      for (int k = 0; k < NUM_SUP; k++) begin
        if (op_idx == OP_W'(k)) sel_pitch = sup_set[k];
      end
    end
  end
endmodule

// File: rtl/pinc_pm_add.sv
module pinc_pm_add
  import pinc_pkg::*;
(
  input  logic [FNUM_W-1:0] fnum,
  input  logic [PMS_W-1:0]  pms,
  input  logic [PM_W-1:0]   pm_ofs,
  output logic [SUM_W-1:0]  base
);
  logic [SUM_W-1:0] ofs_ext;
  assign ofs_ext = {{(SUM_W-PM_W){pm_ofs[PM_W-1]}}, pm_ofs};

  always_comb begin
    if (pms == '0) base = {1'b0, fnum};
    else           base = {fnum, 1'b0} + ofs_ext;  // wraps modulo 2^SUM_W
  end

  always_comb begin
    if (pms == '0)
      AST_RAW_NARROW: assert (base[SUM_W-1] == 1'b0); // R2
  end
endmodule

// File: rtl/pinc_oct_shift.sv
module pinc_oct_shift
  import pinc_pkg::*;
(
  input  logic [SUM_W-1:0] base,
  input  logic [BLK_W-1:0] blk,
  output logic [INC_W-1:0] inc
);
  logic [INC_W-1:0] wide;
  assign wide = INC_W'(base);

  always_comb begin
    if (blk == '0) inc = wide >> 1;
    else           inc = wide << (blk - BLK_W'(1));
  end

  always_comb begin
    if (blk == '0)
      AST_OCT0_NARROW: assert (inc < INC_W'(1 << (SUM_W-1))); // R4
  end
endmodule

// File: rtl/pinc_gen.sv
module pinc_gen
  import pinc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      spec_en,
  input  logic [OP_W-1:0]           op_idx,
  input  logic [FNUM_W-1:0]         chan_fnum,
  input  logic [BLK_W-1:0]          chan_block,
  input  logic [NUM_SUP*FNUM_W-1:0] sup_fnum,
  input  logic [NUM_SUP*BLK_W-1:0]  sup_block,
  input  logic [PMS_W-1:0]          pms,
  input  logic [PM_W-1:0]           pm_ofs,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [INC_W-1:0]          out_inc
);
  pitch_t           chan_pitch, sel_pitch;
  logic [SUM_W-1:0] base;
  logic [INC_W-1:0] inc_next;
  logic             accept;

  assign chan_pitch = '{fnum: chan_fnum, blk: chan_block};

  pinc_src_sel u_sel (
    .spec_en   (spec_en),
    .op_idx    (op_idx),
    .chan_pitch(chan_pitch),
    .sup_fnum  (sup_fnum),
    .sup_block (sup_block),
    .sel_pitch (sel_pitch)
  );

  pinc_pm_add u_pm (
    .fnum  (sel_pitch.fnum),
    .pms   (pms),
    .pm_ofs(pm_ofs),
    .base  (base)
  );

  pinc_oct_shift u_oct (
    .base(base),
    .blk (sel_pitch.blk),
    .inc (inc_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_inc   <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_inc   <= inc_next;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_inc)); // R8
endmodule

// File: tb/pinc_gen_tb.sv
module pinc_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic spec_en = 1'b0;
  logic [1:0] op_idx = '0;
  logic [10:0] chan_fnum = '0;
  logic [2:0] chan_block = '0;
  logic [32:0] sup_fnum;
  logic [8:0] sup_block;
  logic [2:0] pms = '0;
  logic [7:0] pm_ofs = '0;
  logic out_valid, out_ready = 1'b1;
  logic [17:0] out_inc;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  // set0: 0x123/oct2, set1: 0x456/oct0, set2: 0x7FF/oct7
  assign sup_fnum  = {11'h7FF, 11'h456, 11'h123};
  assign sup_block = {3'd7, 3'd0, 3'd2};

  pinc_gen dut_i (.*);

  typedef struct packed {
    logic        spec;
    logic [1:0]  op;
    logic [2:0]  pms;
    logic [7:0]  ofs;
    logic [10:0] fnum;
    logic [2:0]  blk;
    logic [17:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 3'd0, 8'h00, 11'h400, 3'd4, 18'h02000}, // R2 R5
    '{1'b0, 2'd0, 3'd0, 8'h55, 11'h2AB, 3'd0, 18'h00155}, // R4, R2 ofs ignored
    '{1'b0, 2'd0, 3'd3, 8'h05, 11'h400, 3'd1, 18'h00805}, // R3
    '{1'b0, 2'd0, 3'd2, 8'hFD, 11'h000, 3'd1, 18'h00FFD}, // R3 negative wrap
    '{1'b0, 2'd0, 3'd7, 8'h7F, 11'h7FF, 3'd7, 18'h01F40}, // R3 positive wrap
    '{1'b1, 2'd0, 3'd0, 8'h00, 11'h001, 3'd1, 18'h00246}, // R6 set0
    '{1'b1, 2'd1, 3'd0, 8'h00, 11'h001, 3'd1, 18'h0022B}, // R6 set1
    '{1'b1, 2'd2, 3'd0, 8'h00, 11'h001, 3'd1, 18'h1FFC0}, // R6 set2
    '{1'b1, 2'd3, 3'd0, 8'h00, 11'h0F0, 3'd3, 18'h003C0}, // R6 op3 channel
    '{1'b0, 2'd2, 3'd0, 8'h00, 11'h100, 3'd2, 18'h00200}, // R6 op ignored
    '{1'b1, 2'd2, 3'd1, 8'h10, 11'h001, 3'd1, 18'h00380}, // R3 R6
    '{1'b0, 2'd0, 3'd0, 8'h00, 11'h7FF, 3'd7, 18'h1FFC0}  // R5 max
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    spec_en = v.spec; op_idx = v.op; pms = v.pms; pm_ofs = v.ofs;
    chan_fnum = v.fnum; chan_block = v.blk; in_valid = 1'b1;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_inc", out_inc, 0);
    check("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", out_valid, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 valid", out_valid, 1);
      check($sformatf("vector %0d R2-R6 inc", i), out_inc, VECS[i].exp);
      @(negedge clk);
      check("R7 drained", out_valid, 0);
    end

    // R8 back-pressure
    out_ready = 1'b0;
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[2]);
    repeat (3) @(negedge clk);
    check("R8 held valid", out_valid, 1);
    check("R8 held inc", out_inc, VECS[0].exp);
    check("R8 in_ready low", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next result", out_inc, VECS[2].exp);
    check("R8 next valid", out_valid, 1);
    @(negedge clk);
    check("R7 idle", out_valid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule